// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block turns single commands into I2C line activity on a wired-AND bus. A command can open a transfer with a START, shift one byte out, shift one byte in, or close the transfer with a STOP. The block never drives a line high. It only pulls SCL or SDA low through an output enable, and it works from the levels it reads back from the bus. Received data, the acknowledge seen after a byte is sent, and an arbitration-loss flag come back with a one-cycle completion pulse.

Each SCL half period is the value on `half_div` in system clocks. A 100 MHz system clock gives 100 kHz with 500 and 400 kHz with 125. Each high phase is timed from the moment SCL actually reads high, so a slave that holds SCL low stretches the clock. While the block sends a one it compares SDA with what it drives. On a mismatch it lets go of both lines at once. A line monitor marks the bus busy when another master sends a START. A new START from this block waits until a STOP is seen, or until SCL has stayed high with no edge for `IDLE_TMO` cycles.

Top module: `i2c_line_master`

## Requirements
- R1: During and after reset both output enables are 0, `cmd_ready` is 1, `done` is 0 and `bus_busy` is 0.
- R2: Op code 0 (START) lets SDA fall while SCL is high and then pulls SCL low. At its `done` both enables are 1, so the bus is held with SCL low.
- R3: Op code 1 (WRITE) sends `cmd_data` MSB first in eight SCL clocks and releases SDA on the ninth. SDA changes only while SCL is low, so no START or STOP appears on the line except those the commands ask for.
- R4: After a WRITE, `nack` is 1 when SDA read high on the ninth clock and 0 when it read low.
- R5: Op code 2 (READ) releases SDA for eight clocks and returns the sampled byte, MSB first, on `rx_data`. On the ninth clock it pulls SDA low when `cmd_nack` is 0 and leaves SDA high when `cmd_nack` is 1.
- R6: Op code 3 (STOP) pulls SDA low while SCL is low, releases SCL, and then releases SDA while SCL is high. At its `done` both enables are 0.
- R7: After releasing SCL, the block starts counting the high phase only once SCL reads high. A slave holding SCL low therefore lengthens the low phase, and the high phase still lasts at least `half_div` cycles.
- R8: If SDA reads low during the high phase of a data bit where the block sends a one, both enables drop to 0 and the command ends with `done` and `arb_lost` set to 1.
- R9: A START on the line that this block did not send sets `bus_busy`. While the bus is busy and this block does not own it, `cmd_ready` is 0 whenever `cmd_op` is START. A STOP on the line clears `bus_busy`.
- R10: `bus_busy` clears after SCL has read high with no edge for `IDLE_TMO` cycles, even when no STOP is seen.
- R11: Every SCL low phase and every SCL high phase produced by the block lasts at least `half_div` cycles.
- R12: `cmd_ready` is 0 from the cycle after a command is accepted until it completes. `done` is a single-cycle pulse for each command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | SCL half period in system clocks |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The offered command can be accepted |
| cmd_op | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data | input | 8 | Byte to send for WRITE |
| cmd_nack | input | 1 | For READ: 1 leaves the ninth bit high |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Byte received by the last READ |
| nack | output | 1 | Slave left the ninth bit of the last WRITE high |
| arb_lost | output | 1 | The last command lost arbitration |
| bus_busy | output | 1 | A transfer is in progress on the line |
| scl_in | input | 1 | Level read from SCL |
| sda_in | input | 1 | Level read from SDA |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench sets `half_div` to 10 and builds the block with `IDLE_TMO` set to 200. With these values every bit takes a few dozen cycles, and the idle timeout that clears a stale busy flag expires within a short wait. A slave model holds SCL low for 25 cycles after every falling edge. Because that is longer than the half period, the block has to wait for SCL to rise, which exercises the stretching path. A second master on SDA is used to trigger both the busy lockout and a loss of arbitration.

// File: rtl/i2c_line_master.sv
module i2c_line_master #(
  parameter int DIV_W    = 16,
  parameter int IDLE_TMO = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_data,
  input  logic             cmd_nack,
  output logic             done,
  output logic [7:0]       rx_data,
  output logic             nack,
  output logic             arb_lost,
  output logic             bus_busy,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int TMO_W = $clog2(IDLE_TMO + 1);

  typedef enum logic [3:0] {
    IDLE, S_PRE, S_RISE, S_FALL, S_LOW, B_LOW, B_HIGH, P_LOW, P_HIGH, P_REL
  } st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic             rd, nk, own;
  logic [2:0]       scl_q, sda_q;
  logic [TMO_W-1:0] idle_cnt;

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];

  wire [DIV_W:0] cnt_nx = {1'b0, cnt} + (DIV_W+1)'(1);
  wire tick      = cnt_nx >= {1'b0, half_div};
  wire start_det = scl_s && scl_p && sda_p && !sda_s;
  wire stop_det  = scl_s && scl_p && !sda_p && sda_s;
  wire tmo       = idle_cnt == TMO_W'(IDLE_TMO);
  wire obit      = (bitn == 4'd8) ? (rd ? nk : 1'b1) : (rd ? 1'b1 : sh[7]);
  wire arb_miss  = scl_s && !rd && (bitn < 4'd8) && sh[7] && !sda_s;

  assign cmd_ready = (st == IDLE) && !(cmd_op == 2'd0 && bus_busy && !own);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 3'b111;
      sda_q    <= 3'b111;
      bus_busy <= 1'b0;
      idle_cnt <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
      if (start_det)            bus_busy <= 1'b1;
      else if (stop_det || tmo) bus_busy <= 1'b0;
      if (!scl_s || scl_s != scl_p || start_det) idle_cnt <= '0;
      else if (!tmo)                             idle_cnt <= idle_cnt + TMO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;  cnt <= '0;  bitn <= '0;  sh <= '0;
      rd <= 1'b0;  nk <= 1'b0; own <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
      done <= 1'b0; rx_data <= '0; nack <= 1'b0; arb_lost <= 1'b0;
    end else begin
      done <= 1'b0;
      cnt  <= cnt + DIV_W'(1);
      case (st)
        IDLE: begin
          cnt <= '0;
          if (cmd_valid && cmd_ready) begin
            arb_lost <= 1'b0;
            nack     <= 1'b0;
            bitn     <= '0;
            sh       <= cmd_data;
            rd       <= cmd_op == 2'd2;
            nk       <= cmd_nack;
            case (cmd_op)
              2'd0:    st <= S_PRE;
              2'd3:    st <= P_LOW;
              default: st <= B_LOW;
            endcase
          end
        end
        S_PRE: begin
          sda_oe <= 1'b0;
          if (tick) begin st <= S_RISE; cnt <= '0; end
        end
        S_RISE: begin
          scl_oe <= 1'b0;
          if (!scl_s)    cnt <= '0;
          else if (tick) begin st <= S_FALL; cnt <= '0; end
        end
        S_FALL: begin
          sda_oe <= 1'b1;
          if (tick) begin st <= S_LOW; cnt <= '0; end
        end
        S_LOW: begin
          scl_oe <= 1'b1;
          if (tick) begin st <= IDLE; own <= 1'b1; done <= 1'b1; end
        end
        B_LOW: begin
          scl_oe <= 1'b1;
          sda_oe <= !obit;
          if (tick) begin st <= B_HIGH; cnt <= '0; end
        end
        B_HIGH: begin
          scl_oe <= 1'b0;
          if (arb_miss) begin
            sda_oe   <= 1'b0;
            own      <= 1'b0;
            arb_lost <= 1'b1;
            done     <= 1'b1;
            st       <= IDLE;
          end else if (!scl_s) begin
            cnt <= '0;
          end else if (tick) begin
            cnt <= '0;
            if (bitn == 4'd8) begin
              scl_oe <= 1'b1;
              done   <= 1'b1;
              st     <= IDLE;
              if (rd) rx_data <= sh;
              else    nack    <= sda_s;
            end else begin
              sh   <= {sh[6:0], sda_s};
              bitn <= bitn + 4'd1;
              st   <= B_LOW;
            end
          end
        end
        P_LOW: begin
          scl_oe <= 1'b1;
          sda_oe <= 1'b1;
          if (tick) begin st <= P_HIGH; cnt <= '0; end
        end
        P_HIGH: begin
          scl_oe <= 1'b0;
          if (!scl_s)    cnt <= '0;
          else if (tick) begin st <= P_REL; cnt <= '0; end
        end
        P_REL: begin
          sda_oe <= 1'b0;
          if (tick) begin st <= IDLE; own <= 1'b0; done <= 1'b1; end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module i2c_line_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_op,
  input logic       done,
  input logic       arb_lost,
  input logic       bus_busy,
  input logic       scl_oe,
  input logic       sda_oe
);
  logic [1:0] last_op;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_op <= 2'd0;
    else if (cmd_valid && cmd_ready) last_op <= cmd_op;

  a_r2_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && last_op == 2'd0 && !arb_lost |-> scl_oe && sda_oe);
  a_r6_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    done && last_op == 2'd3 |-> !scl_oe && !sda_oe);
  a_r8_lost_frees: assert property (@(posedge clk) disable iff (!rst_n)
    done && arb_lost |-> !scl_oe && !sda_oe);
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready && cmd_op == 2'd0 && bus_busy |-> scl_oe);
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
endmodule

bind i2c_line_master i2c_line_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .done(done), .arb_lost(arb_lost), .bus_busy(bus_busy),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_line_master_tb_top.sv
module i2c_line_master_tb_top;
  localparam int HALF = 10;
  localparam int TMO  = 200;
  localparam int STR  = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cmd_valid = 1'b0, cmd_nack = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_ready, done, nack, arb_lost, bus_busy, scl_oe, sda_oe;
  logic [7:0] rx_data;

  logic om_sda = 1'b0, rmode = 1'b0, ack_en = 1'b1, stretch_en = 1'b0;
  logic [7:0] rbyte = 8'h00;
  int drv_pos = 0, rpos = 0, str_cnt = 0;
  int low_len = 0, high_len = 0, min_low = 1000000, min_high = 1000000, max_low = 0;
  int n_start = 0, n_stop = 0, n_chk = 0, n_fail = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic [8:0] shv = '0;
  logic [8:0] obs_q[$];
  logic [7:0] r_rx;
  logic r_nack, r_arb;
  logic [8:0] ob;

  wire sl_scl = stretch_en && str_cnt > 0;
  wire sl_sda = rmode ? (drv_pos < 8 && !rbyte[3'(7 - drv_pos)]) : (drv_pos == 8 && ack_en);
  wire scl = !(scl_oe || sl_scl);
  wire sda = !(sda_oe || sl_sda || om_sda);

  always #5 clk = !clk;

  i2c_line_master #(.DIV_W(16), .IDLE_TMO(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_div(16'(HALF)),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack), .done(done), .rx_data(rx_data),
    .nack(nack), .arb_lost(arb_lost), .bus_busy(bus_busy),
    .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (str_cnt > 0) str_cnt <= str_cnt - 1;
      if (prev_scl && scl && prev_sda && !sda) begin n_start++; rpos = 0; shv = '0; end
      if (prev_scl && scl && !prev_sda && sda) n_stop++;
      if (!prev_scl && scl) begin
        if (low_len < min_low) min_low = low_len;
        if (low_len > max_low) max_low = low_len;
        shv = {shv[7:0], sda};
        rpos++;
        if (rpos == 9) obs_q.push_back(shv);
        high_len = 0;
      end
      if (prev_scl && !scl) begin
        if (high_len < min_high) min_high = high_len;
        if (rpos >= 9) rpos = 0;
        drv_pos = rpos;
        str_cnt <= STR;
        low_len = 0;
      end
      if (scl) high_len++; else low_len++;
      prev_scl = scl;
      prev_sda = sda;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] d, input logic nk);
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_nack = nk; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R12 ready low while busy", 32'(cmd_ready), 0);
    while (!done) @(negedge clk);
    r_rx = rx_data; r_nack = nack; r_arb = arb_lost;
    @(negedge clk);
    chk("R12 done single cycle", 32'(done), 0);
  endtask

  task automatic pop_byte(input string tag, input logic [8:0] exp);
    if (obs_q.size() == 0) chk(tag, 32'h1ff, 32'(exp));
    else begin ob = obs_q.pop_front(); chk(tag, 32'(ob), 32'(exp)); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 scl_oe", 32'(scl_oe), 0);
    chk("R1 sda_oe", 32'(sda_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 32'(cmd_ready), 1);
    chk("R1 done", 32'(done), 0);
    chk("R1 busy", 32'(bus_busy), 0);

    run_cmd(2'd0, 8'h00, 1'b0);
    chk("R2 holds lines", {30'd0, scl_oe, sda_oe}, 3);
    chk("R2 busy", 32'(bus_busy), 1);

    ack_en = 1'b1;
    run_cmd(2'd1, 8'hA6, 1'b0);
    pop_byte("R3 byte A6 and ack", {8'hA6, 1'b0});
    chk("R4 ack seen", 32'(r_nack), 0);

    ack_en = 1'b0;
    run_cmd(2'd1, 8'h3C, 1'b0);
    pop_byte("R3 byte 3C", {8'h3C, 1'b1});
    chk("R4 nack seen", 32'(r_nack), 1);

    ack_en = 1'b1;
    max_low = 0;
    stretch_en = 1'b1;
    run_cmd(2'd1, 8'h5A, 1'b0);
    stretch_en = 1'b0;
    pop_byte("R7 stretched byte 5A", {8'h5A, 1'b0});
    chk("R7 low stretched", 32'(max_low >= STR - 2), 1);
    chk("R7 high after stretch", 32'(min_high >= HALF), 1);

    rmode = 1'b1; rbyte = 8'hC3;
    run_cmd(2'd2, 8'h00, 1'b0);
    chk("R5 rx C3", 32'(r_rx), 32'hC3);
    pop_byte("R5 master ack", {8'hC3, 1'b0});

    rbyte = 8'h7E;
    run_cmd(2'd2, 8'h00, 1'b1);
    rmode = 1'b0;
    chk("R5 rx 7E", 32'(r_rx), 32'h7E);
    pop_byte("R5 master nack", {8'h7E, 1'b1});

    run_cmd(2'd3, 8'h00, 1'b0);
    chk("R6 released", {30'd0, scl_oe, sda_oe}, 0);
    repeat (5) @(negedge clk);
    chk("R6 busy cleared", 32'(bus_busy), 0);

    om_sda = 1'b1;
    cmd_op = 2'd0;
    repeat (5) @(negedge clk);
    chk("R9 foreign start busy", 32'(bus_busy), 1);
    chk("R9 start blocked", 32'(cmd_ready), 0);
    om_sda = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 stop frees", 32'(bus_busy), 0);
    chk("R9 start allowed", 32'(cmd_ready), 1);

    run_cmd(2'd0, 8'h00, 1'b0);
    om_sda = 1'b1;
    run_cmd(2'd1, 8'hFF, 1'b0);
    chk("R8 lost flag", 32'(r_arb), 1);
    chk("R8 lines free", {30'd0, scl_oe, sda_oe}, 0);
    chk("R10 still busy", 32'(bus_busy), 1);
    repeat (TMO + 30) @(negedge clk);
    chk("R10 timeout frees", 32'(bus_busy), 0);
    om_sda = 1'b0;
    repeat (5) @(negedge clk);

    chk("R3 start count", 32'(n_start), 3);
    chk("R3 stop count", 32'(n_stop), 3);
    chk("R11 min low", 32'(min_low >= HALF), 1);
    chk("R11 min high", 32'(min_high >= HALF), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule